// File: doc/BRIEF.md
# Video Window Crop and Decimator

This block sits in a digitised video pixel stream and turns it into frame-buffer writes. Each incoming pixel is placed on a raster by counting valid pixels since the last line start and lines since the last frame start. A rectangular area of interest, set by a column offset, a width, a line offset and a height, selects which pixels are kept. Every kept pixel comes out as a write strobe with its data and a linear byte address into a frame store of up to 1024 x 1024 bytes.

Two options reshape the output. Halving mode keeps only every second pixel and every second line of the window, so the stored image is half as wide and half as tall. Field-merge mode interleaves two interlaced fields into one progressive frame: the field parity sampled at frame start selects whether the field lands on the even rows or the odd rows of the stored frame. A one-cycle completion pulse travels with the write of the last pixel of the window.

Top module: `vwin_crop_decim`

## Requirements
- R1: After reset `wr_en` and `frame_done` are low, and no write is produced for any pixel until the first `frame_start` has been seen.
- R2: Column numbering: the pixel sent with `frame_start` or `line_start` is column 0 and each later valid pixel adds one. A pixel is inside the window horizontally when `cfg_hoff <= col < cfg_hoff + H`, where H is `cfg_hsize` with its two low bits forced to zero, then raised to 4 if smaller and lowered to 1024 if larger.
- R3: Line numbering: the line carrying `frame_start` is line 0 and each `line_start` adds one. A line is inside the window when `cfg_voff <= line < cfg_voff + V`, where V is `cfg_vsize` raised to 1 if zero and lowered to 1024 if larger.
- R4: With both options off, a kept pixel at window-relative position (x, y) is written one cycle after it arrives, with the same data, to address `y*H + x`, truncated to 20 bits.
- R5: With `cfg_decim` high, only pixels with even x and even y are written, to address `(y/2)*(H/2) + x/2`.
- R6: With `cfg_deint` high, the output row r becomes `2*r + p`, where p is `field_odd` sampled together with `frame_start` (1 = odd field); the address is then `row*width + column` with the width of R4 or R5.
- R7: `frame_done` is high for exactly one cycle, together with the write of the pixel at the last kept column (H-1, or H-2 when halving) of the last kept line (V-1, or the largest even number not above V-1 when halving).
- R8: After `frame_done`, no write occurs until the next `frame_start`, even if more lines arrive.
- R9: A cycle with `pix_valid` low produces no write and does not advance the column count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_valid | input | 1 | Pixel present on `pix_data` this cycle |
| pix_data | input | PIX_W (8) | Pixel value |
| line_start | input | 1 | This cycle begins a new line |
| frame_start | input | 1 | This cycle begins a new field or frame (line 0) |
| field_odd | input | 1 | Field parity, sampled with `frame_start` |
| cfg_hoff | input | COORD_W (10) | First window column |
| cfg_hsize | input | COORD_W+1 (11) | Window width, multiple of four |
| cfg_voff | input | COORD_W (10) | First window line |
| cfg_vsize | input | COORD_W+1 (11) | Window height in lines |
| cfg_decim | input | 1 | Keep every second pixel and line |
| cfg_deint | input | 1 | Interleave fields into alternate rows |
| wr_en | output | 1 | Frame-buffer write strobe |
| wr_data | output | PIX_W (8) | Data to write |
| wr_addr | output | 2*COORD_W (20) | Linear byte address |
| frame_done | output | 1 | Last window pixel is being written |

## Verification
The stream is driven with windows that start mid-line and mid-frame and with frames that run past the window on both axes, which separates an off-by-one at either edge from a correct crop and shows that nothing is written after completion. Width fields with their low bits set, widths below four and above 1024 and a zero height tell the clamping rules apart from a plain copy of the field. Halving with an odd height, field merge on both parities, and the two together distinguish the row and column scaling from the row interleave, while gaps in `pix_valid` show that the column count only moves on real pixels.

// File: rtl/vwc_pkg.sv
package vwc_pkg;

  // Width rule: low two bits dropped, then held inside [4, max_pix].
  function automatic int unsigned fit_hsize(int unsigned raw, int unsigned max_pix);
    int unsigned v;
    v = raw & 32'hFFFF_FFFC;
    if (v < 4) v = 4;
    if (v > max_pix) v = max_pix;
    return v;
  endfunction

  // Height rule: held inside [1, max_lines].
  function automatic int unsigned fit_vsize(int unsigned raw, int unsigned max_lines);
    int unsigned v;
    v = raw;
    if (v < 1) v = 1;
    if (v > max_lines) v = max_lines;
    return v;
  endfunction

  // Stored width of one output row.
  function automatic int unsigned kept_span(int unsigned size, logic halve);
    return halve ? (size >> 1) : size;
  endfunction

  // Last relative coordinate that survives the optional halving.
  function automatic int unsigned last_kept(int unsigned size, logic halve);
    int unsigned top;
    top = size - 1;
    return halve ? (top & 32'hFFFF_FFFE) : top;
  endfunction

  // Frame row after the optional field interleave.
  function automatic int unsigned buf_row(int unsigned orow, logic merge, logic odd);
    return merge ? ((orow << 1) | {31'd0, odd}) : orow;
  endfunction

  function automatic int unsigned lin_addr(int unsigned row, int unsigned col,
                                           int unsigned width);
    return row * width + col;
  endfunction

endpackage

// File: rtl/vwc_raster.sv
module vwc_raster #(
  parameter int COORD_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_valid,
  input  logic               line_start,
  input  logic               frame_start,
  input  logic               field_odd,
  output logic [COORD_W:0]   cur_col,
  output logic [COORD_W:0]   cur_line,
  output logic               cur_odd,
  output logic               cur_armed
);
  localparam int CNT_W = COORD_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] col_q, line_q;
  logic             odd_q, armed_q;

  always_comb begin
    cur_col = (frame_start || line_start) ? '0 : col_q;
    if (frame_start)
      cur_line = '0;
    else if (line_start && line_q != CNT_MAX)
      cur_line = line_q + 1'b1;
    else
      cur_line = line_q;
    cur_odd   = frame_start ? field_odd : odd_q;
    cur_armed = frame_start || armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= '0;
      line_q  <= '0;
      odd_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      col_q   <= (pix_valid && cur_col != CNT_MAX) ? cur_col + 1'b1 : cur_col;
      line_q  <= cur_line;
      odd_q   <= cur_odd;
      armed_q <= cur_armed;
    end
  end
endmodule

// File: rtl/vwc_window.sv
module vwc_window
  import vwc_pkg::*;
#(
  parameter int COORD_W = 10
) (
  input  logic               pix_valid,
  input  logic               armed,
  input  logic [COORD_W:0]   cur_col,
  input  logic [COORD_W:0]   cur_line,
  input  logic [COORD_W-1:0] cfg_hoff,
  input  logic [COORD_W:0]   cfg_hsize,
  input  logic [COORD_W-1:0] cfg_voff,
  input  logic [COORD_W:0]   cfg_vsize,
  input  logic               cfg_decim,
  output logic               keep,
  output logic               last_pix,
  output logic [COORD_W-1:0] rel_x,
  output logic [COORD_W-1:0] rel_y,
  output logic [COORD_W+1:0] h_sz
);
  localparam int SZ_W    = COORD_W + 2;
  localparam int MAX_DIM = 1 << COORD_W;

  logic [SZ_W-1:0] v_sz, dx, dy, lx, ly;
  logic            in_h, in_v, grid_ok;

  assign h_sz = SZ_W'(fit_hsize(32'(cfg_hsize), MAX_DIM));
  assign v_sz = SZ_W'(fit_vsize(32'(cfg_vsize), MAX_DIM));
  assign lx   = SZ_W'(last_kept(32'(h_sz), cfg_decim));
  assign ly   = SZ_W'(last_kept(32'(v_sz), cfg_decim));

  assign dx = {1'b0, cur_col} - {2'b00, cfg_hoff};
  assign dy = {1'b0, cur_line} - {2'b00, cfg_voff};

  assign in_h    = ({1'b0, cur_col} >= {2'b00, cfg_hoff}) && (dx < h_sz);
  assign in_v    = ({1'b0, cur_line} >= {2'b00, cfg_voff}) && (dy < v_sz);
  assign grid_ok = !cfg_decim || (!dx[0] && !dy[0]);

  assign keep     = pix_valid && armed && in_h && in_v && grid_ok;
  assign last_pix = keep && (dx == lx) && (dy == ly);
  assign rel_x    = dx[COORD_W-1:0];
  assign rel_y    = dy[COORD_W-1:0];
endmodule

// File: rtl/vwc_addr.sv
module vwc_addr
  import vwc_pkg::*;
#(
  parameter int COORD_W = 10,
  parameter int PIX_W   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   keep,
  input  logic                   last_pix,
  input  logic [COORD_W-1:0]     rel_x,
  input  logic [COORD_W-1:0]     rel_y,
  input  logic [COORD_W+1:0]     h_sz,
  input  logic                   cfg_decim,
  input  logic                   cfg_deint,
  input  logic                   odd,
  input  logic [PIX_W-1:0]       pix_data,
  output logic                   wr_en,
  output logic [PIX_W-1:0]       wr_data,
  output logic [2*COORD_W-1:0]   wr_addr,
  output logic                   frame_done
);
  localparam int ADDR_W = 2 * COORD_W;

  logic [COORD_W-1:0] ox, oy;
  logic [ADDR_W-1:0]  nxt_addr;

  assign ox = cfg_decim ? (rel_x >> 1) : rel_x;
  assign oy = cfg_decim ? (rel_y >> 1) : rel_y;
  assign nxt_addr = ADDR_W'(lin_addr(buf_row(32'(oy), cfg_deint, odd), 32'(ox),
                                     kept_span(32'(h_sz), cfg_decim)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en      <= 1'b0;
      frame_done <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
    end else begin
      wr_en      <= keep;
      frame_done <= last_pix;
      if (keep) begin
        wr_addr <= nxt_addr;
        wr_data <= pix_data;
      end
    end
  end
endmodule

// File: rtl/vwin_crop_decim.sv
module vwin_crop_decim #(
  parameter int COORD_W = 10,
  parameter int PIX_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pix_valid,
  input  logic [PIX_W-1:0]     pix_data,
  input  logic                 line_start,
  input  logic                 frame_start,
  input  logic                 field_odd,
  input  logic [COORD_W-1:0]   cfg_hoff,
  input  logic [COORD_W:0]     cfg_hsize,
  input  logic [COORD_W-1:0]   cfg_voff,
  input  logic [COORD_W:0]     cfg_vsize,
  input  logic                 cfg_decim,
  input  logic                 cfg_deint,
  output logic                 wr_en,
  output logic [PIX_W-1:0]     wr_data,
  output logic [2*COORD_W-1:0] wr_addr,
  output logic                 frame_done
);
  logic [COORD_W:0]   cur_col, cur_line;
  logic               cur_odd, cur_armed;
  logic               ev_keep, ev_last;
  logic [COORD_W-1:0] rel_x, rel_y;
  logic [COORD_W+1:0] h_sz;

  vwc_raster #(.COORD_W(COORD_W)) u_raster (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .line_start(line_start),
    .frame_start(frame_start), .field_odd(field_odd), .cur_col(cur_col),
    .cur_line(cur_line), .cur_odd(cur_odd), .cur_armed(cur_armed)
  );

  vwc_window #(.COORD_W(COORD_W)) u_window (
    .pix_valid(pix_valid), .armed(cur_armed), .cur_col(cur_col), .cur_line(cur_line),
    .cfg_hoff(cfg_hoff), .cfg_hsize(cfg_hsize), .cfg_voff(cfg_voff),
    .cfg_vsize(cfg_vsize), .cfg_decim(cfg_decim), .keep(ev_keep),
    .last_pix(ev_last), .rel_x(rel_x), .rel_y(rel_y), .h_sz(h_sz)
  );

  vwc_addr #(.COORD_W(COORD_W), .PIX_W(PIX_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .keep(ev_keep), .last_pix(ev_last), .rel_x(rel_x),
    .rel_y(rel_y), .h_sz(h_sz), .cfg_decim(cfg_decim), .cfg_deint(cfg_deint),
    .odd(cur_odd), .pix_data(pix_data), .wr_en(wr_en), .wr_data(wr_data),
    .wr_addr(wr_addr), .frame_done(frame_done)
  );
endmodule

// File: rtl/vwc_check.sv
module vwc_check (
  input logic clk,
  input logic rst_n,
  input logic pix_valid,
  input logic frame_start,
  input logic cfg_decim,
  input logic ev_keep,
  input logic wr_en,
  input logic frame_done
);
  logic done_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           done_seen <= 1'b0;
    else if (frame_start) done_seen <= 1'b0;
    else if (frame_done)  done_seen <= 1'b1;
  end

  a_r7_done_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> wr_en);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  a_r8_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_seen |-> !wr_en);

  a_r9_write_needs_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(pix_valid));

  a_r4_keep_becomes_write: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_keep |=> !wr_en);

  a_r5_no_adjacent_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en) && !$past(frame_start)) |-> !$past(cfg_decim));
endmodule

bind vwin_crop_decim vwc_check u_check (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .frame_start(frame_start),
  .cfg_decim(cfg_decim), .ev_keep(ev_keep), .wr_en(wr_en), .frame_done(frame_done)
);

// File: tb/sim_vwin_crop_decim.sv
module sim_vwin_crop_decim;
  localparam int CLK_NS = 10;

  typedef struct {
    logic [19:0] addr;
    logic [7:0]  data;
    logic        done;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_valid = 1'b0, line_start = 1'b0, frame_start = 1'b0, field_odd = 1'b0;
  logic [7:0]  pix_data = '0;
  logic [9:0]  hoff = '0, voff = '0;
  logic [10:0] hsize = 11'd4, vsize = 11'd1;
  logic        decim = 1'b0, deint = 1'b0;
  logic        wr_en, frame_done;
  logic [7:0]  wr_data;
  logic [19:0] wr_addr;

  exp_t  q[$];
  int    checks = 0, errs = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  vwin_crop_decim u0 (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .line_start(line_start), .frame_start(frame_start), .field_odd(field_odd),
    .cfg_hoff(hoff), .cfg_hsize(hsize), .cfg_voff(voff), .cfg_vsize(vsize),
    .cfg_decim(decim), .cfg_deint(deint), .wr_en(wr_en), .wr_data(wr_data),
    .wr_addr(wr_addr), .frame_done(frame_done)
  );

  // Monitor: pops one expected write per observed strobe.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (wr_en) begin
        checks++;
        if (q.size() == 0) begin
          errs++;
          $display("FAIL %s/R8: unexpected write addr=%h data=%h, expected no write",
                   cur_req, wr_addr, wr_data);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (wr_addr !== e.addr || wr_data !== e.data || frame_done !== e.done) begin
            errs++;
            $display("FAIL %s: addr=%h data=%h done=%b, expected addr=%h data=%h done=%b",
                     cur_req, wr_addr, wr_data, frame_done, e.addr, e.data, e.done);
          end
        end
      end else if (frame_done) begin
        checks++;
        errs++;
        $display("FAIL R7: done=1 without write, expected done=0");
      end
    end
  end

  task automatic drive(input bit fs, input bit ls, input bit v, input logic [7:0] d,
                       input bit odd);
    @(negedge clk);
    frame_start = fs;
    line_start  = ls;
    pix_valid   = v;
    pix_data    = d;
    field_odd   = odd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 8'h00, field_odd);
  endtask

  // Driver: computes expected writes from the requirements and plays the field.
  task automatic run_frame(input int lines, input int pix, input bit odd,
                           input bit gaps, input string req);
    int he, ve, lx, ly, w, rx, ry, ox, oy, row, d;
    exp_t e;
    he = (int'(hsize) / 4) * 4;
    if (he < 4) he = 4;
    if (he > 1024) he = 1024;
    ve = int'(vsize);
    if (ve < 1) ve = 1;
    if (ve > 1024) ve = 1024;
    lx = decim ? he - 2 : he - 1;
    ly = decim ? (ve - 1) - ((ve - 1) % 2) : ve - 1;
    w  = decim ? he / 2 : he;
    cur_req = req;
    for (int l = 0; l < lines; l++) begin
      for (int c = 0; c < pix; c++) begin
        if (gaps && (c % 3 == 1)) drive(0, 0, 0, 8'hEE, odd);
        d  = (l * 13 + c * 5 + (odd ? 7 : 0)) % 256;
        rx = c - int'(hoff);
        ry = l - int'(voff);
        if (rx >= 0 && rx < he && ry >= 0 && ry < ve &&
            (!decim || (rx % 2 == 0 && ry % 2 == 0))) begin
          ox  = decim ? rx / 2 : rx;
          oy  = decim ? ry / 2 : ry;
          row = deint ? 2 * oy + (odd ? 1 : 0) : oy;
          e.addr = 20'(row * w + ox);
          e.data = 8'(d);
          e.done = (rx == lx && ry == ly);
          q.push_back(e);
        end
        drive(l == 0 && c == 0, c == 0 && l > 0, 1, 8'(d), odd);
      end
      drive(0, 0, 0, 8'h00, odd);
    end
    idle(3);
    checks++;
    if (q.size() != 0) begin
      errs++;
      $display("FAIL %s: missing writes=%0d, expected 0", req, q.size());
      q.delete();
    end
  endtask

  task automatic set_cfg(input int ho, input int hs, input int vo, input int vs,
                         input bit dc, input bit di);
    idle(2);
    hoff = 10'(ho); hsize = 11'(hs); voff = 10'(vo); vsize = 11'(vs);
    decim = dc; deint = di;
    idle(2);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      finished = 1'b1;
      errs++;
      checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (wr_en !== 1'b0 || frame_done !== 1'b0) begin
      errs++;
      $display("FAIL R1: wr_en=%b done=%b, expected 0 0", wr_en, frame_done);
    end
    // R1: pixels before any frame start must not be written
    set_cfg(0, 8, 0, 4, 0, 0);
    cur_req = "R1";
    for (int l = 0; l < 2; l++)
      for (int c = 0; c < 8; c++) drive(0, c == 0, 1, 8'(c), 0);
    idle(3);

    // R2 R3 R4: plain crop, frame larger than the window (R8 extra lines)
    set_cfg(3, 8, 2, 3, 0, 0);
    run_frame(8, 16, 0, 0, "R4");
    // R2 low size bits ignored, R9 pixel gaps
    set_cfg(5, 11, 0, 4, 0, 0);
    run_frame(6, 20, 0, 1, "R9");
    // R2 R3 lower clamps: width 2 -> 4, height 0 -> 1
    set_cfg(0, 2, 0, 0, 0, 0);
    run_frame(3, 10, 0, 0, "R3");
    // R2 upper clamp: width 2047 -> 1024, window past line end
    set_cfg(1000, 2047, 0, 2, 0, 0);
    run_frame(2, 1030, 0, 0, "R2");
    // R5 halving with odd height, R7 completion
    set_cfg(1, 12, 1, 5, 1, 0);
    run_frame(9, 20, 0, 0, "R5");
    run_frame(9, 20, 0, 1, "R7");
    // R6 field merge, both parities
    set_cfg(0, 8, 1, 3, 0, 1);
    run_frame(6, 12, 0, 0, "R6");
    run_frame(6, 12, 1, 0, "R6");
    // R6 with R5: merge and halve
    set_cfg(2, 16, 0, 6, 1, 1);
    run_frame(7, 20, 1, 1, "R6");
    run_frame(7, 20, 0, 0, "R5");

    idle(4);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule